// File: doc/BRIEF.md
# Serial Channel DMA Request Generator

This block produces the two active-low DMA request lines of one serial channel. It also holds the channel's transmit FIFO (4 bytes) and receive FIFO (8 bytes). A DMA controller or CPU writes transmit bytes with a low-going write strobe, and the serial shifter takes them from the head of the FIFO with a pop pulse. The shifter pushes received bytes into the receive FIFO, and the DMA controller drains them with a low-going read strobe.

The shared line (`req_a_n`) can be selected to request either transmit data or receive data. It is held high whenever it is not both selected and enabled. The second line (`req_b_n`) can only request transmit data, so full-duplex operation runs receive on the shared line and transmit on the dedicated one. A transmit threshold bit chooses between two policies. In one, a request is raised only when the transmit FIFO is empty, giving one falling edge per byte. In the other, a request is raised whenever there is room, which keeps the FIFO topped up. The transmit readiness qualifier that drives the request is also exported for interrupt logic. The receive request ignores the receive threshold bit, which affects only the exported receive interrupt qualifier.

All configuration lives in one 6-bit register written through `cfg_we`/`cfg_wdata`. The bit layout is `[5]` shared-line enable, `[4]` shared-line request select, `[3]` shared-line direction (0 transmit, 1 receive), `[2]` dedicated-line enable, `[1]` transmit empty-only threshold, `[0]` receive half-full threshold. The reset value is `6'b000010`. A configuration write takes effect on the request pins one clock after the write edge.

Top module: `ser_dma_req`

## Requirements
- R1: After reset both request pins are high, both FIFOs are empty (`tx_has_data`=0, `rx_irq_ready`=0) and the transmit threshold bit is 1, so `tx_ready`=1.
- R2: With cfg[5]=1, cfg[4]=1, cfg[3]=0, `req_a_n` is low while the transmit FIFO is ready to accept a byte.
- R3: Whenever cfg[5] or cfg[4] is 0, `req_a_n` is high from the next clock onward. This includes the case where the line is selected but not enabled.
- R4: The first clock edge that samples `tx_wr_n` low after it was high pushes one byte (if the FIFO is not full) and drives every transmit-carrying request pin high at that same edge.
- R5: After such a release the transmit request stays high for two clock edges before it can fall again. A strobe held low pushes exactly one byte.
- R6: With cfg[1]=1, the transmit request and `tx_ready` are active only while the transmit FIFO holds zero bytes.
- R7: With cfg[1]=0, the transmit request and `tx_ready` are active while the transmit FIFO holds fewer than 4 bytes, so the DMA can fill all 4 entries.
- R8: A write strobe while the transmit FIFO is full is ignored. Occupancy and contents are unchanged and the request stays high.
- R9: With cfg[5:3]=3'b111, `req_a_n` is low whenever the receive FIFO holds at least one byte, regardless of cfg[0]. cfg[0] only moves `rx_irq_ready` to a threshold of 4 bytes.
- R10: The edge that samples a falling `rx_rd_n` and removes the last receive byte drives `req_a_n` high. If a new byte is pushed in the same cycle, the request stays low.
- R11: With cfg[2]=1, `req_b_n` carries only the transmit request. With cfg[2]=0 it is high.
- R12: Both FIFOs are first-in first-out. `tx_rdata`/`rx_rdata` show the oldest byte, and occupancy never exceeds the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 6 | Configuration register write value |
| tx_wr_n | input | 1 | Active-low transmit data write strobe |
| tx_wdata | input | 8 | Transmit byte to store |
| tx_pop | input | 1 | Shifter takes the head transmit byte |
| tx_rdata | output | 8 | Head of the transmit FIFO |
| tx_has_data | output | 1 | Transmit FIFO holds at least one byte |
| tx_ready | output | 1 | Shared transmit readiness qualifier |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_rd_n | input | 1 | Active-low receive data read strobe |
| rx_rdata | output | 8 | Head of the receive FIFO |
| rx_irq_ready | output | 1 | Receive interrupt qualifier (uses threshold bit) |
| req_a_n | output | 1 | Shared transmit/receive request, active low |
| req_b_n | output | 1 | Transmit-only request, active low |

## Verification
Two pairs of events can fall on the same clock edge. The first is a read strobe that removes the last receive byte while the shifter pushes a new one. The bench drives both on one edge and expects the shared line to stay low, then reads the surviving byte back. The second is a transmit write strobe arriving while the FIFO is full, or alongside a shifter pop. The bench fills the FIFO, writes an extra byte and drains it. It judges the result by the order of the bytes that come out and by `tx_has_data` going low exactly after the fourth pop.

// File: rtl/sdr_pkg.sv
`timescale 1ns/1ps
package sdr_pkg;
  typedef struct packed {
    logic a_en;
    logic a_sel;
    logic a_dir;
    logic b_en;
    logic tx_empty_only;
    logic rx_half;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
  localparam logic [CFG_W-1:0] CFG_RST = 6'b000010;
endpackage

// File: rtl/sdr_cfg.sv
`timescale 1ns/1ps
module sdr_cfg
  import sdr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg
);
  always_ff @(posedge clk) begin
    if (rst)     cfg <= cfg_t'(CFG_RST);
    else if (we) cfg <= cfg_t'(wdata);
  end
endmodule

// File: rtl/sdr_fifo.sv
`timescale 1ns/1ps
module sdr_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] level_nxt
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             push_ok, pop_ok;

  assign push_ok = push && (level != FULL_LVL);
  assign pop_ok  = pop && (level != '0);

  always_comb begin
    level_nxt = level;
    if (push_ok && !pop_ok) level_nxt = level + LVL_W'(1);
    if (pop_ok && !push_ok) level_nxt = level - LVL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == LAST_PTR) ? '0 : wptr + PTR_W'(1);
      if (pop_ok)  rptr <= (rptr == LAST_PTR) ? '0 : rptr + PTR_W'(1);
      level <= level_nxt;
    end
  end

  assign dout = mem[rptr];

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && level == FULL_LVL) |=> (level == FULL_LVL));

  // R12
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_LVL);
endmodule

// File: rtl/sdr_tx_req.sv
`timescale 1ns/1ps
module sdr_tx_req #(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] level_nxt,
  input  logic             empty_only,
  output logic             wr_fall,
  output logic             act_nxt,
  output logic             ready
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic wr_n_q, hold_q, ready_nxt;

  assign wr_fall   = wr_n_q && !wr_n;
  assign ready     = empty_only ? (level == '0) : (level < FULL_LVL);
  assign ready_nxt = empty_only ? (level_nxt == '0) : (level_nxt < FULL_LVL);
  assign act_nxt   = !wr_fall && !hold_q && ready_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_n_q <= 1'b1;
      hold_q <= 1'b0;
    end else begin
      wr_n_q <= wr_n;
      hold_q <= wr_fall;
    end
  end

  // R5
  hold_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    wr_fall |=> !act_nxt);
endmodule

// File: rtl/ser_dma_req.sv
`timescale 1ns/1ps
module ser_dma_req
  import sdr_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 8,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [5:0]        cfg_wdata,
  input  logic              tx_wr_n,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_rdata,
  output logic              tx_has_data,
  output logic              tx_ready,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic              rx_rd_n,
  output logic [DATA_W-1:0] rx_rdata,
  output logic              rx_irq_ready,
  output logic              req_a_n,
  output logic              req_b_n
);
  localparam int TX_LVL_W = $clog2(TX_DEPTH + 1);
  localparam int RX_LVL_W = $clog2(RX_DEPTH + 1);
  localparam logic [RX_LVL_W-1:0] RX_FULL = RX_LVL_W'(RX_DEPTH);
  localparam logic [RX_LVL_W-1:0] RX_HALF = RX_LVL_W'(RX_DEPTH / 2);

  cfg_t                cfg_q;
  logic [TX_LVL_W-1:0] tx_level, tx_level_nxt;
  logic [RX_LVL_W-1:0] rx_level, rx_level_nxt;
  logic                wr_fall, tx_act_nxt, rx_act_nxt;
  logic                rd_n_q, rd_fall;
  logic                a_tx, a_rx;

  sdr_cfg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg_q)
  );

  sdr_fifo #(.DEPTH(TX_DEPTH), .W(DATA_W)) u_tx_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (wr_fall),
    .din       (tx_wdata),
    .pop       (tx_pop),
    .dout      (tx_rdata),
    .level     (tx_level),
    .level_nxt (tx_level_nxt)
  );

  sdr_tx_req #(.DEPTH(TX_DEPTH)) u_tx_req (
    .clk        (clk),
    .rst        (rst),
    .wr_n       (tx_wr_n),
    .level      (tx_level),
    .level_nxt  (tx_level_nxt),
    .empty_only (cfg_q.tx_empty_only),
    .wr_fall    (wr_fall),
    .act_nxt    (tx_act_nxt),
    .ready      (tx_ready)
  );

  assign rd_fall = rd_n_q && !rx_rd_n;

  sdr_fifo #(.DEPTH(RX_DEPTH), .W(DATA_W)) u_rx_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (rx_push),
    .din       (rx_wdata),
    .pop       (rd_fall),
    .dout      (rx_rdata),
    .level     (rx_level),
    .level_nxt (rx_level_nxt)
  );

  // receive request is deliberately blind to cfg_q.rx_half
  assign rx_act_nxt   = (rx_level_nxt != '0);
  assign rx_irq_ready = cfg_q.rx_half ? (rx_level >= RX_HALF) : (rx_level != '0);
  assign tx_has_data  = (tx_level != '0);

  assign a_tx = cfg_q.a_en && cfg_q.a_sel && !cfg_q.a_dir;
  assign a_rx = cfg_q.a_en && cfg_q.a_sel &&  cfg_q.a_dir;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_n_q  <= 1'b1;
      req_a_n <= 1'b1;
      req_b_n <= 1'b1;
    end else begin
      rd_n_q  <= rx_rd_n;
      req_a_n <= !((a_tx && tx_act_nxt) || (a_rx && rx_act_nxt));
      req_b_n <= !(cfg_q.b_en && tx_act_nxt);
    end
  end

  // R3
  a_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_q.a_en && cfg_q.a_sel) |=> req_a_n);

  // R11
  b_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.b_en |=> req_b_n);

  // R4
  tx_release_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_fall && !a_rx) |=> (req_a_n && req_b_n));

  // R5
  tx_gap_chk: assert property (@(posedge clk) disable iff (rst)
    wr_fall |=> ##1 req_b_n);

  // R9
  rx_req_chk: assert property (@(posedge clk) disable iff (rst)
    (a_rx && rx_push && rx_level != RX_FULL) |=> !req_a_n);

  // R10
  rx_last_read_chk: assert property (@(posedge clk) disable iff (rst)
    (a_rx && rd_fall && rx_level == RX_LVL_W'(1) && !rx_push) |=> req_a_n);
endmodule

// File: tb/test_ser_dma_req.sv
`timescale 1ns/1ps
module test_ser_dma_req;
  localparam int A_EN  = 32;
  localparam int A_SEL = 16;
  localparam int A_DIR = 8;
  localparam int B_EN  = 4;
  localparam int TXE   = 2;
  localparam int RXH   = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic       tx_wr_n = 1'b1;
  logic [7:0] tx_wdata = '0;
  logic       tx_pop = 1'b0;
  logic [7:0] tx_rdata;
  logic       tx_has_data, tx_ready;
  logic       rx_push = 1'b0;
  logic [7:0] rx_wdata = '0;
  logic       rx_rd_n = 1'b1;
  logic [7:0] rx_rdata;
  logic       rx_irq_ready, req_a_n, req_b_n;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ser_dma_req i_ser_dma_req (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_wr_n(tx_wr_n), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
    .tx_rdata(tx_rdata), .tx_has_data(tx_has_data), .tx_ready(tx_ready),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_rd_n(rx_rd_n),
    .rx_rdata(rx_rdata), .rx_irq_ready(rx_irq_ready),
    .req_a_n(req_a_n), .req_b_n(req_b_n)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int v);
    cfg_wdata = 6'(v);
    cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
    step();
  endtask

  task automatic wr_byte(input int d);
    tx_wdata = 8'(d);
    tx_wr_n = 1'b0;
    step();
    tx_wr_n = 1'b1;
    step();
  endtask

  task automatic pop_tx();
    tx_pop = 1'b1;
    step();
    tx_pop = 1'b0;
  endtask

  task automatic push_rx(input int d);
    rx_wdata = 8'(d);
    rx_push = 1'b1;
    step();
    rx_push = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();

    // R1 reset state
    check("R1 req_a_n", req_a_n, 1);
    check("R1 req_b_n", req_b_n, 1);
    check("R1 tx_has_data", tx_has_data, 0);
    check("R1 tx_ready", tx_ready, 1);
    check("R1 rx_irq_ready", rx_irq_ready, 0);

    // R3 selected but not enabled, enabled but not selected
    set_cfg(A_SEL | TXE);
    check("R3 sel no en", req_a_n, 1);
    set_cfg(A_EN | TXE);
    check("R3 en no sel", req_a_n, 1);

    // R2 transmit request on shared line
    set_cfg(A_EN | A_SEL | TXE);
    check("R2 req_a_n low", req_a_n, 0);
    check("R11 b disabled", req_b_n, 1);

    // R4 release at strobe edge, R5 gap, R6 empty-only hold
    tx_wdata = 8'hA1;
    tx_wr_n = 1'b0;
    step();
    check("R4 release", req_a_n, 1);
    tx_wr_n = 1'b1;
    step();
    check("R5 gap", req_a_n, 1);
    step();
    check("R6 stays high with 1 byte", req_a_n, 1);
    check("R6 tx_ready", tx_ready, 0);
    check("R12 tx head", tx_rdata, 8'hA1);

    // R5 held-low strobe pushes one byte
    tx_wdata = 8'hA2;
    tx_wr_n = 1'b0;
    repeat (5) step();
    tx_wr_n = 1'b1;
    step();
    pop_tx();
    check("R12 tx second", tx_rdata, 8'hA2);
    check("R6 one byte left", req_a_n, 1);
    pop_tx();
    check("R5 single push", tx_has_data, 0);
    check("R6 empty requests", req_a_n, 0);

    // R7 fill with any-space threshold
    set_cfg(A_EN | A_SEL);
    for (int i = 0; i < 4; i++) begin
      wr_byte(16 + i);
      step();
      check("R7 fill request", req_a_n, (i + 1 < 4) ? 0 : 1);
    end

    // R8 write while full ignored
    wr_byte(8'hEE);
    step();
    check("R8 request high when full", req_a_n, 1);
    for (int i = 0; i < 4; i++) begin
      check("R8 order", tx_rdata, 16 + i);
      pop_tx();
    end
    check("R8 no extra byte", tx_has_data, 0);

    // R6/R7 sweep of threshold against occupancy
    for (int thr = 0; thr < 2; thr++) begin
      for (int n = 0; n <= 4; n++) begin
        set_cfg(A_EN | A_SEL | (thr != 0 ? TXE : 0));
        for (int k = 0; k < n; k++) wr_byte(k);
        step();
        check(thr != 0 ? "R6 sweep ready" : "R7 sweep ready", tx_ready,
              (thr != 0) ? int'(n == 0) : int'(n < 4));
        check(thr != 0 ? "R6 sweep pin" : "R7 sweep pin", req_a_n,
              (thr != 0) ? int'(n != 0) : int'(n >= 4));
        for (int k = 0; k < n; k++) pop_tx();
        step();
      end
    end

    // R9 receive request ignores threshold bit
    set_cfg(A_EN | A_SEL | A_DIR | RXH);
    check("R9 empty rx", req_a_n, 1);
    push_rx(8'h50);
    check("R9 one byte requests", req_a_n, 0);
    check("R9 irq uses threshold", rx_irq_ready, 0);
    for (int i = 1; i < 4; i++) push_rx(8'h50 + i);
    check("R9 irq at half", rx_irq_ready, 1);
    for (int i = 0; i < 4; i++) begin
      check("R12 rx order", rx_rdata, 8'h50 + i);
      rx_rd_n = 1'b0;
      step();
      check(i < 3 ? "R9 still requesting" : "R10 last read releases",
            req_a_n, (i < 3) ? 0 : 1);
      rx_rd_n = 1'b1;
      step();
    end

    // R10 last read coinciding with a push
    push_rx(8'h60);
    rx_wdata = 8'h61;
    rx_push = 1'b1;
    rx_rd_n = 1'b0;
    step();
    check("R10 concurrent push keeps request", req_a_n, 0);
    rx_push = 1'b0;
    rx_rd_n = 1'b1;
    step();
    check("R10 surviving byte", rx_rdata, 8'h61);
    rx_rd_n = 1'b0;
    step();
    check("R10 release after drain", req_a_n, 1);
    rx_rd_n = 1'b1;
    step();

    // R11 dedicated line carries transmit only
    set_cfg(A_EN | A_SEL | A_DIR | B_EN | TXE);
    check("R11 b requests tx", req_b_n, 0);
    check("R11 a idle rx empty", req_a_n, 1);
    push_rx(8'h70);
    wr_byte(8'h71);
    step();
    check("R11 b released by tx byte", req_b_n, 1);
    check("R11 a follows rx", req_a_n, 0);
    pop_tx();
    check("R11 b re-requests", req_b_n, 0);
    rx_rd_n = 1'b0;
    step();
    rx_rd_n = 1'b1;
    step();
    check("R11 a released", req_a_n, 1);

    // R3/R11 everything disabled
    set_cfg(0);
    check("R3 disabled a", req_a_n, 1);
    check("R11 disabled b", req_b_n, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule